// File: doc/BRIEF.md
# Bus-Attached Converter Sequencer

This block is the digital control side of a multiplexed analog-to-digital converter that sits on an 8-bit microprocessor-style bus. The host selects the part with an active-low chip select. A write cycle places a configuration byte on the shared data bus. That byte carries a 5-bit channel address and three format selects: sign mode, resolution and justification. The end of the write latches the configuration and starts a sequence. An acquisition phase of fixed length is followed by a conversion phase, and the length of the conversion depends on the chosen resolution.

The analog front end is modelled by a 10-bit offset-binary sample input. That input is captured on the last cycle of acquisition. When conversion finishes, an active-low interrupt falls. The host then reads the result. While read and chip select are both low, the formatted byte is driven and the bus output enable is high. A read also lifts the interrupt. A 10-bit result comes back as two reads, high byte first. An 8-bit result takes a single read.

All strobes are sampled on the block clock. A write that arrives during a running sequence discards that sequence and starts again with the new configuration.

Top module: `adc_bus_seq`

## Requirements
- R1: After reset, int_n is 1, db_oe is 0, mux_addr is 0 and no sequence runs.
- R2: Write and read strobes are ignored while cs_n is 1: no sequence starts, mux_addr keeps its value, db_oe stays 0 and int_n keeps its level.
- R3: The end of a write (the first clock edge at which cs_n=0 and wr_n=0 no longer holds) loads mux_addr from db_in[4:0] as it was during the write; mux_addr changes at no other time.
- R4: Configuration bit positions are: db_in[5]=1 selects signed output, db_in[6]=1 selects 8-bit resolution, and db_in[7]=1 selects left justification.
- R5: With 10-bit resolution, int_n is 1 after the 27th clock edge following the write-end edge and 0 after the 28th edge (6 acquisition plus 22 conversion cycles).
- R6: With 8-bit resolution, int_n is 1 after the 23rd edge following the write-end edge and 0 after the 24th edge (6 plus 18).
- R7: samp_in is captured on the 6th edge after the write-end edge; later changes do not alter the result.
- R8: db_oe equals (cs_n=0 and rd_n=0); db_out is 0 whenever db_oe is 0.
- R9: A read (cs_n=0, rd_n=0) sets int_n to 1 by the next clock edge.
- R10: In 8-bit mode a read returns sample bits [9:2]; in signed mode the top bit of that byte is inverted (two's complement). Every read returns the same byte.
- R11: In 10-bit mode the result is a 16-bit word that is read high byte first, then low byte, and then wraps. Right justification places the 10 bits at [9:0], zero-extended when unsigned and sign-extended when signed. Left justification places them at [15:6] with zeros below. Signed mode inverts sample bit 9.
- R12: A write during a running sequence aborts it. int_n is 1 after the write-end edge, and timing restarts from that edge with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all phases are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; gates both strobes |
| wr_n | input | 1 | Active-low write strobe; its end starts a sequence |
| rd_n | input | 1 | Active-low read strobe |
| db_in | input | 8 | Bus value driven by the host (configuration byte) |
| samp_in | input | 10 | Offset-binary sample from the analog model |
| db_out | output | 8 | Result byte driven toward the bus |
| db_oe | output | 1 | Bus output enable for db_out |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| mux_addr | output | 5 | Latched channel address for the analog multiplexer |

## Verification
A phase counter that is off by one shows up directly as int_n falling a cycle early or late. For that reason the bench samples int_n on both sides of the expected edge, in both resolution modes. A byte pointer or configuration latch in the wrong state shows up on the first read after completion, as a swapped, misaligned or wrongly extended byte. A sample captured at the wrong moment is caught by changing samp_in once acquisition has ended. A restart that fails to clear the old sequence makes int_n fall at the old deadline, and that is observable within one conversion.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    // Field order mirrors the bus bit positions: [7] left, [6] res8, [5] sgn, [4:0] addr
    typedef struct packed {
        logic              left;
        logic              res8;
        logic              sgn;
        logic [ADDR_W-1:0] addr;
    } cfg_t;
endpackage

// File: rtl/adc_strobe_edges.sv
module adc_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_act,
    output logic rd_act,
    output logic wr_end,
    output logic rd_end
);
    typedef struct packed {
        logic wr;
        logic rd;
    } edg_s;

    edg_s edg_d, edg_q;

    always_comb begin
        wr_act   = !cs_n && !wr_n;
        rd_act   = !cs_n && !rd_n;
        edg_d.wr = wr_act;
        edg_d.rd = rd_act;
        wr_end   = edg_q.wr && !wr_act;
        rd_end   = edg_q.rd && !rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    AST_CS_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !edg_q.wr) |=> !wr_end) else $error("cs gate"); // R2
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int ACQ_CYC  = 6,
    parameter int CONV_HI  = 22,
    parameter int CONV_LO  = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic res8,
    output logic capture,
    output logic done,
    output logic busy
);
    import adc_bus_pkg::*;

    localparam int MAXC = (ACQ_CYC > CONV_HI) ? ACQ_CYC : CONV_HI;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;
    logic [CW-1:0] conv_last;

    always_comb begin
        tmr_d     = tmr_q;
        capture   = 1'b0;
        done      = 1'b0;
        conv_last = res8 ? CW'(CONV_LO - 1) : CW'(CONV_HI - 1);
        case (tmr_q.ph)
            PH_ACQ: begin
                if (tmr_q.cnt == CW'(ACQ_CYC - 1)) begin
                    capture   = 1'b1;
                    tmr_d.ph  = PH_CONV;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
            PH_CONV: begin
                if (tmr_q.cnt == conv_last) begin
                    done      = 1'b1;
                    tmr_d.ph  = PH_IDLE;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
            default: begin
                tmr_d.ph  = PH_IDLE;
                tmr_d.cnt = '0;
            end
        endcase
        if (start) begin
            capture   = 1'b0;
            done      = 1'b0;
            tmr_d.ph  = PH_ACQ;
            tmr_d.cnt = '0;
        end
        busy = (tmr_q.ph != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{ph: PH_IDLE, cnt: '0};
        else        tmr_q <= tmr_d;
    end

    AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.ph == PH_ACQ) |-> (tmr_q.cnt < CW'(ACQ_CYC))) else $error("acq"); // R7
    AST_CONV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.ph == PH_CONV) |-> (tmr_q.cnt <= conv_last)) else $error("conv"); // R5
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done)) else $error("restart"); // R12
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] code,
    input  logic             sgn,
    input  logic             res8,
    input  logic             left,
    input  logic             lo_sel,
    output logic [BUS_W-1:0] byte_out
);
    localparam int WORD_W = 2 * BUS_W;
    localparam int PAD_W  = WORD_W - RES_W;

    logic [RES_W-1:0]  val;
    logic [WORD_W-1:0] word;

    always_comb begin
        val = sgn ? (code ^ (RES_W'(1) << (RES_W - 1))) : code;
        if (left) word = {val, {PAD_W{1'b0}}};
        else      word = {{PAD_W{sgn & val[RES_W-1]}}, val};
        if (res8)        byte_out = val[RES_W-1 -: BUS_W];
        else if (lo_sel) byte_out = word[BUS_W-1:0];
        else             byte_out = word[WORD_W-1 -: BUS_W];
    end
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq #(
    parameter int RES_W   = 10,
    parameter int ACQ_CYC = 6,
    parameter int CONV_HI = 22,
    parameter int CONV_LO = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        wr_n,
    input  logic                        rd_n,
    input  logic [adc_bus_pkg::BUS_W-1:0]  db_in,
    input  logic [RES_W-1:0]            samp_in,
    output logic [adc_bus_pkg::BUS_W-1:0]  db_out,
    output logic                        db_oe,
    output logic                        int_n,
    output logic [adc_bus_pkg::ADDR_W-1:0] mux_addr
);
    import adc_bus_pkg::*;

    typedef struct packed {
        cfg_t             hold;
        cfg_t             cfg;
        logic [RES_W-1:0] samp;
        logic             irq_n;
        logic             lo_sel;
    } top_s;

    top_s st_d, st_q;
    logic wr_act, rd_act, wr_end, rd_end;
    logic capture, done, busy;
    logic [BUS_W-1:0] fmt_byte;

    adc_strobe_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .wr_act (wr_act),
        .rd_act (rd_act),
        .wr_end (wr_end),
        .rd_end (rd_end)
    );

    adc_phase_timer #(
        .ACQ_CYC (ACQ_CYC),
        .CONV_HI (CONV_HI),
        .CONV_LO (CONV_LO)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_end),
        .res8    (st_q.cfg.res8),
        .capture (capture),
        .done    (done),
        .busy    (busy)
    );

    adc_result_fmt #(
        .RES_W (RES_W),
        .BUS_W (BUS_W)
    ) u_fmt (
        .code     (st_q.samp),
        .sgn      (st_q.cfg.sgn),
        .res8     (st_q.cfg.res8),
        .left     (st_q.cfg.left),
        .lo_sel   (st_q.lo_sel),
        .byte_out (fmt_byte)
    );

    always_comb begin
        st_d = st_q;
        if (wr_act)  st_d.hold = cfg_t'(db_in);
        if (wr_end)  st_d.cfg  = st_q.hold;
        if (capture) st_d.samp = samp_in;

        if (wr_end)      st_d.irq_n = 1'b1;
        else if (done)   st_d.irq_n = 1'b0;
        else if (rd_act) st_d.irq_n = 1'b1;

        if (wr_end || done)             st_d.lo_sel = 1'b0;
        else if (rd_end && !st_q.cfg.res8) st_d.lo_sel = !st_q.lo_sel;

        db_oe    = rd_act;
        db_out   = rd_act ? fmt_byte : '0;
        int_n    = st_q.irq_n;
        mux_addr = st_q.cfg.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !done) |=> int_n) else $error("read clear"); // R9
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!db_oe && db_out == '0)) else $error("oe gate"); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_end |=> $stable(mux_addr)) else $error("addr hold"); // R3
    AST_IRQ_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> (!busy && $past(busy))) else $error("irq"); // R5
    AST_NEW_WRITE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> (int_n && busy)) else $error("new write"); // R12
endmodule

// File: tb/adc_bus_seq_test.sv
module adc_bus_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] db_in = '0;
    logic [9:0] samp_in = '0;
    logic [7:0] db_out;
    logic       db_oe, int_n;
    logic [4:0] mux_addr;

    int n_chk = 0, n_bad = 0;
    logic [7:0] rb;

    always #5 clk = ~clk;

    adc_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .db_in(db_in), .samp_in(samp_in), .db_out(db_out), .db_oe(db_oe),
        .int_n(int_n), .mux_addr(mux_addr)
    );

    // {cfg, 6'b0+sample, expected first byte, expected second byte}
    localparam logic [39:0] VEC [8] = '{
        {8'h03, 6'd0, 10'h2A5, 8'h02, 8'hA5},  // R11 unsigned right
        {8'h25, 6'd0, 10'h0F0, 8'hFE, 8'hF0},  // R11 signed right, negative
        {8'h87, 6'd0, 10'h3C1, 8'hF0, 8'h40},  // R11 unsigned left
        {8'hA1, 6'd0, 10'h155, 8'hD5, 8'h40},  // R11 signed left
        {8'h4A, 6'd0, 10'h3FF, 8'hFF, 8'hFF},  // R10 unsigned 8-bit
        {8'h6C, 6'd0, 10'h200, 8'h00, 8'h00},  // R10 signed 8-bit midscale
        {8'hDF, 6'd0, 10'h1FF, 8'h7F, 8'h7F},  // R10 justification ignored
        {8'h3E, 6'd0, 10'h3FF, 8'h01, 8'hFF}   // R11 signed right, positive
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] cfg, input logic cs_val);
        @(negedge clk); cs_n = cs_val; wr_n = 1'b0; db_in = cfg;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; db_in = '0;   // write-end edge has passed
    endtask

    task automatic do_read(output logic [7:0] val, input string req);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check({req, " oe"}, {15'd0, db_oe}, 16'd1);
        val = db_out;
        @(negedge clk);
        check("R9", {15'd0, int_n}, 16'd1);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_irq(input int len, input string req);
        repeat (len + 5) @(negedge clk);
        check({req, " early"}, {15'd0, int_n}, 16'd1);
        @(negedge clk);
        check({req, " edge"}, {15'd0, int_n}, 16'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 int", {15'd0, int_n}, 16'd1);
        check("R1 oe", {15'd0, db_oe}, 16'd0);
        check("R1 addr", {11'd0, mux_addr}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            logic [7:0] cfg;
            int len;
            cfg = VEC[i][39:32];
            samp_in = VEC[i][25:16];
            len = cfg[6] ? 18 : 22;   // R4 db_in[6] selects 8-bit
            do_write(cfg, 1'b0);
            check("R3", {11'd0, mux_addr}, {11'd0, cfg[4:0]});
            wait_irq(len, cfg[6] ? "R6" : "R5");
            do_read(rb, "R8");
            check(cfg[6] ? "R10 first" : "R11 high", {8'd0, rb}, {8'd0, VEC[i][15:8]});
            do_read(rb, "R8");
            check(cfg[6] ? "R10 repeat" : "R11 low", {8'd0, rb}, {8'd0, VEC[i][7:0]});
            if (!cfg[6]) begin
                do_read(rb, "R8");
                check("R11 wrap", {8'd0, rb}, {8'd0, VEC[i][15:8]});
                do_read(rb, "R8");
            end
        end

        // R2: cs high write/read ignored
        samp_in = 10'h100;
        do_write(8'h45, 1'b0);
        wait_irq(18, "R6");
        do_write(8'h1B, 1'b1);
        check("R2 addr", {11'd0, mux_addr}, 16'h0005);
        @(negedge clk); rd_n = 1'b0; #1;
        check("R2 oe", {15'd0, db_oe}, 16'd0);
        check("R8 bus idle", {8'd0, db_out}, 16'd0);
        @(negedge clk);
        check("R2 int", {15'd0, int_n}, 16'd0);
        rd_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R2 no start", {15'd0, int_n}, 16'd0);
        do_read(rb, "R8");
        check("R10 value", {8'd0, rb}, 16'h0040);

        // R7: sample change after acquisition has no effect
        samp_in = 10'h2F0;
        do_write(8'h40, 1'b0);
        repeat (8) @(negedge clk);
        samp_in = 10'h005;
        repeat (10) @(negedge clk);
        check("R7 busy", {15'd0, int_n}, 16'd1);
        repeat (6) @(negedge clk);
        check("R7 done", {15'd0, int_n}, 16'd0);
        do_read(rb, "R8");
        check("R7 sample", {8'd0, rb}, 16'h00BC);

        // R12: restart during conversion, 10-bit then new 8-bit config
        samp_in = 10'h0C4;
        do_write(8'h09, 1'b0);
        repeat (12) @(negedge clk);
        do_write(8'h52, 1'b0);
        check("R12 int high", {15'd0, int_n}, 16'd1);
        check("R12 addr", {11'd0, mux_addr}, 16'h0012);
        wait_irq(18, "R12");
        do_read(rb, "R8");
        check("R12 result", {8'd0, rb}, 16'h0031);

        // R12: write after completion forces int_n high
        do_write(8'h03, 1'b0);
        wait_irq(22, "R5");
        do_write(8'h03, 1'b0);
        check("R12 int forced", {15'd0, int_n}, 16'd1);
        wait_irq(22, "R5");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule